// File: doc/BRIEF.md
# Serial CRC-4 Generator and Checker

This block computes a four-bit cyclic redundancy code one bit per clock for the generator x^4 + x^3 + 1, written as the divisor pattern 11001. The remainder lives in a four-stage register that shifts left. The top stage is the feedback term, and it is folded back into the stages that hold the nonzero lower coefficients. Bits enter most significant first, one bit on each cycle in which `valid_i` is high. `start_i` marks the first bit of a frame and `last_i` marks the final bit.

In generate mode the block treats the message as though four zero bits followed it. The remainder of that padded message is the frame check sequence, kept with any leading zeros. The four padding steps are folded into the last bit's cycle, so the caller sends only the message bits. In check mode the caller sends the received message followed by its received check bits. A zero remainder accepts the frame, and any nonzero remainder raises `err_o`. The result appears one cycle after the last bit and holds until the next frame starts.

Top module: `crc4_serial_unit`

## Requirements
- R1: After reset, `crc_o` is 0000 and `err_o` is 0.
- R2: In generate mode (`mode_i`=0), the message 1001101 (first bit first) gives `crc_o`=1011. This is the remainder of the message times x^4, divided modulo 2 by 11001.
- R3: In generate mode the four zero padding bits are applied internally. The result is on `crc_o` in the cycle after the cycle that accepts the bit with `last_i` high.
- R4: In check mode (`mode_i`=1), the frame 10011011011 leaves remainder 0000 on `crc_o` with `err_o`=0. Any message followed by its own generated check bits is also accepted.
- R5: In check mode, the frame 10010011011 leaves remainder 1111 on `crc_o` with `err_o`=1. `err_o` is high only when the remainder shown is nonzero.
- R6: A bit accepted with `start_i` high is shifted into an all-zero register, whatever earlier frames left behind. Frames may follow each other with no idle cycle.
- R7: In cycles where `valid_i` is low, `bit_i`, `start_i` and `last_i` have no effect.
- R8: `crc_o` and `err_o` hold their values until the next accepted start. A start without last clears both to zero in the following cycle.
- R9: The mode is sampled with the start bit. Changes on `mode_i` later in the frame are ignored.
- R10: In generate mode `err_o` stays 0.
- R11: A one-bit frame, with start and last in the same cycle, gives the correct result. For example, generate mode on bit 1 gives 1001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | `bit_i` is accepted this cycle |
| start_i | input | 1 | Accepted bit is the first of a frame |
| last_i | input | 1 | Accepted bit is the final one of a frame |
| bit_i | input | 1 | Serial data bit, most significant first |
| mode_i | input | 1 | 0 = generate, 1 = check; sampled with start |
| crc_o | output | 4 | Check sequence (generate) or remainder (check) |
| err_o | output | 1 | Check mode: remainder is nonzero |

## Verification
A wrong remainder state reaches the ports only through `crc_o`, one cycle after the frame's last bit. A corrupted tap or a missing feedback term therefore stays hidden during the frame and then shows as a wrong check value or a flipped `err_o` at frame end. The bench pushes many lengths and patterns through both modes for this reason. These include one-bit frames and frames sent back to back, which expose a clear that is missing or comes late. Idle cycles that carry junk strobes expose state that changes while `valid_i` is low.

// File: rtl/crc4_pkg.sv
package crc4_pkg;
  localparam int unsigned CRC_W = 4;
  // lower generator coefficients (x^3 + x^0); x^4 is the feedback term
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b1001;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } crc_mode_e;
endpackage

// File: rtl/crc4_stage.sv
module crc4_stage #(
  parameter int unsigned W = crc4_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc4_pkg::CRC_POLY
) (
  input  logic [W-1:0] state_i,
  input  logic         din_i,
  output logic [W-1:0] next_o
);
  logic fb;
  assign fb = state_i[W-1];

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign next_o[i] = din_i ^ (POLY[i] & fb);
    end else begin : g_upper
      assign next_o[i] = state_i[i-1] ^ (POLY[i] & fb);
    end
  end
endmodule

// File: rtl/crc4_pad.sv
module crc4_pad #(
  parameter int unsigned W = crc4_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc4_pkg::CRC_POLY
) (
  input  logic [W-1:0] state_i,
  output logic [W-1:0] padded_o
);
  logic [W:0][W-1:0] chain;
  assign chain[0] = state_i;

  // one zero-bit shift per stage of the register
  for (genvar k = 0; k < W; k++) begin : g_zero
    crc4_stage #(.W(W), .POLY(POLY)) u_stage (
      .state_i(chain[k]),
      .din_i  (1'b0),
      .next_o (chain[k+1])
    );
  end

  assign padded_o = chain[W];
endmodule

// File: rtl/crc4_shift.sv
module crc4_shift #(
  parameter int unsigned W = crc4_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc4_pkg::CRC_POLY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         start_i,
  input  logic         bit_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] base;

  // start discards the previous frame in the same cycle
  assign base = start_i ? '0 : state_q;

  crc4_stage #(.W(W), .POLY(POLY)) u_stage (
    .state_i(base),
    .din_i  (bit_i),
    .next_o (next_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else if (valid_i) state_q <= next_o;
  end

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));

  p_start_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i && !bit_i) |=> (state_q == '0));
endmodule

// File: rtl/crc4_result.sv
module crc4_result #(
  parameter int unsigned W = crc4_pkg::CRC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         start_i,
  input  logic         last_i,
  input  logic         chk_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] padded_i,
  output logic [W-1:0] crc_o,
  output logic         err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_o <= '0;
      err_o <= 1'b0;
    end else if (valid_i && last_i) begin
      crc_o <= chk_i ? rem_i : padded_i;
      err_o <= chk_i && (|rem_i);
    end else if (valid_i && start_i) begin
      crc_o <= '0;
      err_o <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (start_i || last_i)) |=> ($stable(crc_o) && $stable(err_o)));

  p_start_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i && !last_i) |=> (crc_o == '0 && !err_o));

  p_gen_no_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last_i && !chk_i) |=> !err_o);

  p_err_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (crc_o != '0));
endmodule

// File: rtl/crc4_serial_unit.sv
module crc4_serial_unit
  import crc4_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = CRC_POLY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         start_i,
  input  logic         last_i,
  input  logic         bit_i,
  input  logic         mode_i,
  output logic [W-1:0] crc_o,
  output logic         err_o
);
  crc_mode_e    mode_q;
  crc_mode_e    mode_eff;
  logic [W-1:0] rem;
  logic [W-1:0] padded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_GEN;
    else if (valid_i && start_i) mode_q <= crc_mode_e'(mode_i);
  end

  // a one-bit frame uses the live mode
  assign mode_eff = (valid_i && start_i) ? crc_mode_e'(mode_i) : mode_q;

  crc4_shift #(.W(W), .POLY(POLY)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .start_i(start_i),
    .bit_i  (bit_i),
    .next_o (rem)
  );

  crc4_pad #(.W(W), .POLY(POLY)) u_pad (
    .state_i (rem),
    .padded_o(padded)
  );

  crc4_result #(.W(W)) u_result (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .start_i (start_i),
    .last_i  (last_i),
    .chk_i   (mode_eff == MODE_CHK),
    .rem_i   (rem),
    .padded_i(padded),
    .crc_o   (crc_o),
    .err_o   (err_o)
  );

  p_mode_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && start_i) |=> $stable(mode_q));
endmodule

// File: tb/sim_crc4_serial_unit.sv
module sim_crc4_serial_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0, start_i = 1'b0, last_i = 1'b0, bit_i = 1'b0, mode_i = 1'b0;
  logic [3:0] crc_o;
  logic       err_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  crc4_serial_unit u0 (.*);

  typedef struct packed {
    logic        mode;
    logic [4:0]  len;
    logic [23:0] bits;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 5'd7,  24'h00004D},
    '{1'b1, 5'd11, 24'h0004DB},
    '{1'b1, 5'd11, 24'h00049B},
    '{1'b0, 5'd16, 24'h00A5C3},
    '{1'b0, 5'd1,  24'h000001},
    '{1'b1, 5'd8,  24'h0000FF},
    '{1'b0, 5'd24, 24'hF0F0F0},
    '{1'b1, 5'd5,  24'h000019},
    '{1'b1, 5'd20, 24'h3A5C7}
  };

  // long division by 11001, augmented by x^4 in generate mode
  function automatic logic [3:0] crc_ref(logic mode, int len, logic [23:0] bits);
    logic [27:0] a;
    int total;
    a = {4'b0, bits};
    total = len;
    if (!mode) begin
      a = a << 4;
      total = len + 4;
    end
    for (int i = 27; i >= 4; i--)
      if (i < total && a[i]) a[i -: 5] = a[i -: 5] ^ 5'b11001;
    return a[3:0];
  endfunction

  task automatic check4(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s crc actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s err actual %b expected %b", req, act, exp);
    end
  endtask

  // drives one frame from a negedge; returns at the negedge after the last bit
  task automatic send(logic mode, int len, logic [23:0] bits, int gap, int flip_at);
    for (int i = len - 1; i >= 0; i--) begin
      valid_i = 1'b1;
      bit_i   = bits[i];
      start_i = (i == len - 1);
      last_i  = (i == 0);
      mode_i  = (i == flip_at) ? ~mode : mode;
      @(negedge clk_i);
      if (i != 0) begin
        for (int g = 0; g < gap; g++) begin
          valid_i = 1'b0;
          bit_i = ~bit_i;
          start_i = 1'b1;
          last_i = 1'b1;
          mode_i = ~mode;
          @(negedge clk_i);
        end
      end
    end
    valid_i = 1'b0;
    start_i = 1'b0;
    last_i  = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] fcs;
    repeat (3) @(negedge clk_i);
    check4("R1", crc_o, 4'b0000);
    check1("R1", err_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2, R4, R5: known values
    send(1'b0, 7, 24'h4D, 0, -1);
    check4("R2", crc_o, 4'b1011);
    check1("R10", err_o, 1'b0);
    send(1'b1, 11, 24'h4DB, 0, -1);
    check4("R4", crc_o, 4'b0000);
    check1("R4", err_o, 1'b0);
    send(1'b1, 11, 24'h49B, 0, -1);
    check4("R5", crc_o, 4'b1111);
    check1("R5", err_o, 1'b1);

    // table walk, R3 timing: result sampled one cycle after last
    for (int v = 0; v < NV; v++) begin
      send(TBL[v].mode, int'(TBL[v].len), TBL[v].bits, 0, -1);
      check4("R3", crc_o, crc_ref(TBL[v].mode, int'(TBL[v].len), TBL[v].bits));
      check1("R5", err_o, TBL[v].mode && (crc_ref(TBL[v].mode, int'(TBL[v].len), TBL[v].bits) != 0));
    end

    // R4 round trip
    send(1'b0, 16, 24'hA5C3, 0, -1);
    fcs = crc_o;
    send(1'b1, 20, {4'h0, 16'hA5C3, fcs}, 0, -1);
    check4("R4", crc_o, 4'b0000);
    check1("R4", err_o, 1'b0);

    // R11 single-bit frame
    send(1'b0, 1, 24'h1, 0, -1);
    check4("R11", crc_o, 4'b1001);

    // R7 idle cycles with junk strobes
    send(1'b0, 7, 24'h4D, 2, -1);
    check4("R7", crc_o, 4'b1011);
    send(1'b1, 11, 24'h49B, 1, -1);
    check1("R7", err_o, 1'b1);

    // R8 hold over idle and mid-stream bits without start or last
    repeat (3) @(negedge clk_i);
    valid_i = 1'b1; bit_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check4("R8", crc_o, 4'b1111);
    check1("R8", err_o, 1'b1);
    valid_i = 1'b1; start_i = 1'b1; bit_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; start_i = 1'b0;
    check4("R8", crc_o, 4'b0000);
    check1("R8", err_o, 1'b0);
    // abandon this partial frame; R6 next frame starts clean
    send(1'b0, 7, 24'h4D, 0, -1);
    check4("R6", crc_o, 4'b1011);

    // R6 back-to-back frames, no idle cycle
    send(1'b1, 11, 24'h49B, 0, -1);
    valid_i = 1'b1;
    send(1'b0, 16, 24'hA5C3, 0, -1);
    check4("R6", crc_o, crc_ref(1'b0, 16, 24'hA5C3));

    // R9 mode toggled mid-frame
    send(1'b0, 7, 24'h4D, 0, 3);
    check4("R9", crc_o, 4'b1011);
    check1("R10", err_o, 1'b0);
    send(1'b1, 11, 24'h49B, 0, 5);
    check4("R9", crc_o, 4'b1111);
    check1("R9", err_o, 1'b1);

    // R1 reset mid-result
    rst_ni = 1'b0;
    @(negedge clk_i);
    check4("R1", crc_o, 4'b0000);
    check1("R1", err_o, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule